// File: doc/BRIEF.md
# Checked ALU with Predicted Parity and Single Retry

This block is an ALU datapath with error checking, meant for a processor pipeline where every data word carries a parity bit. It performs add with carry-in, AND, OR and XOR. It does not regenerate the parity of the result from the result itself. Instead it predicts that parity from the operand parities and from internal signals: the carry chain for additions, and the complementary logic vector for AND and OR. It then recomputes the parity of the word it actually produced and compares the two. Additions are also cross-checked by a modulo-3 residue computed with a tree of two-bit residue adders.

An operand that arrives with a parity bit inconsistent with its data is reported as an input-path fault, apart from ALU faults. When the ALU check fails, the block drops that attempt, waits one cycle and re-executes the held operation once. If the second attempt checks clean, the result is delivered with an error pulse. If it fails again, a sticky fatal flag is raised and stays raised until software clears it.

A fault-injection mask input XORs into the produced result word, downstream of the prediction logic. A zero mask gives normal operation. A nonzero mask lets the checking and retry paths be exercised at the ports.

Top module: `checked_alu`

## Requirements
- R1: Opcode 2'b00 adds (result = low W bits of a+b+cin, cout_o = carry out), 2'b01 is AND, 2'b10 is OR, 2'b11 is XOR (cout_o = 0 for the three logic codes). With no fault, the result appears with res_valid_o one cycle after valid_i is sampled.
- R2: All parity is even (parity bit = XOR of the data bits). res_par_o is the predicted parity, and for consistent operands it equals the parity of the correct result. When an operand's parity bit is inverted, res_par_o is inverted once for each inverted operand bit.
- R3: The result delivered is the operation's output XOR flt_mask_i. An ALU error is declared when the recomputed parity differs from the predicted one, or, for opcode 2'b00 only, when ({cout, result} mod 3) differs from ((a mod 3 + b mod 3 + cin) mod 3). A corruption that changes neither is delivered at latency one with no flag.
- R4: On an ALU error the first attempt produces no output. The held operation is re-executed with the mask present in the cycle before delivery, and the retry result appears three cycles after valid_i, with alu_err_o high for that one cycle.
- R5: If the retry also fails its check, fatal_o becomes 1 in the cycle the retry result is delivered. fatal_o stays 1 until clr_fatal_i is sampled high in a cycle with no retry failure. When a retry failure and clr_fatal_i coincide, fatal_o is set.
- R6: If either operand's parity bit disagrees with its data, in_err_o is high with the result at latency one. The ALU check and the retry are skipped, and alu_err_o stays 0.
- R7: valid_i sampled while a retry is pending is ignored: it produces no output and does not disturb the retried operation.
- R8: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Opcode (see R1) |
| a_i | input | W | Operand A |
| a_par_i | input | 1 | Even parity of operand A |
| b_i | input | W | Operand B |
| b_par_i | input | 1 | Even parity of operand B |
| cin_i | input | 1 | Carry in for add |
| flt_mask_i | input | W | Fault-injection XOR mask on the produced result |
| clr_fatal_i | input | 1 | Clears the sticky fatal flag |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | W | Result word |
| res_par_o | output | 1 | Predicted result parity |
| cout_o | output | 1 | Carry out (add only) |
| in_err_o | output | 1 | Operand parity fault pulse |
| alu_err_o | output | 1 | ALU fault detected, retried result pulse |
| fatal_o | output | 1 | Sticky retry-failure flag |

## Verification
The delivery of a failed retry and a software clear of the fatal flag can land on the same clock edge. The bench provokes this by holding clr_fatal_i high exactly in the retry cycle, once with a fault mask that fails again and once with a clean mask. It expects fatal_o to be set in the first case and cleared in the second. A new valid_i arriving during the recovery gap is also driven, and the bench judges it by the absence of an extra result strobe and by the intact retried result.

// File: rtl/chk_alu_pkg.sv
package chk_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GAP   = 2'b01,
        ST_RETRY = 2'b10
    } seq_st_e;

    // residue of a two-bit group (weight 4^k == 1 mod 3)
    function automatic logic [1:0] m3_pair(input logic [1:0] v);
        return (v == 2'd3) ? 2'd0 : v;
    endfunction

    // modulo-3 sum of two residues
    function automatic logic [1:0] m3_add(input logic [1:0] x, input logic [1:0] y);
        logic [2:0] s;
        s = {1'b0, x} + {1'b0, y};
        return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
    endfunction

endpackage

// File: rtl/chk_mod3_tree.sv
module chk_mod3_tree
    import chk_alu_pkg::*;
#(
    parameter int NB = 16
) (
    input  logic [NB-1:0] val_i,
    output logic [1:0]    res_o
);

    localparam int NPAIR = (NB + 1) / 2;
    localparam int LVL   = (NPAIR > 1) ? $clog2(NPAIR) : 0;
    localparam int NLEAF = 1 << LVL;
    localparam int NNODE = 2 * NLEAF - 1;

    logic [2*NLEAF-1:0] padded;
    logic [1:0]         node [NNODE];

    always_comb begin
        padded         = '0;
        padded[NB-1:0] = val_i;
    end

    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        assign node[NLEAF-1+i] = m3_pair(padded[2*i+1 -: 2]);
    end

    for (genvar k = 0; k < NLEAF - 1; k++) begin : g_node
        assign node[k] = m3_add(node[2*k+1], node[2*k+2]);
    end

    assign res_o = node[0];

endmodule

// File: rtl/chk_alu_core.sv
module chk_alu_core
    import chk_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         a_par_i,
    input  logic         b_par_i,
    input  logic [W-1:0] flt_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         pred_par_o,
    output logic         mism_o
);

    localparam int SW = W + 1;

    logic [W-1:0] carry_v;
    logic [W-1:0] sum_v;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] xor_v;
    logic [W-1:0] raw_v;
    logic         add_co;
    logic         par_bad;
    logic         rsd_bad;
    logic [1:0]   r_a;
    logic [1:0]   r_b;
    logic [1:0]   r_s;
    logic [1:0]   r_exp;

    // ripple adder that exposes the carry into every bit
    always_comb begin
        logic c;
        c = cin_i;
        for (int i = 0; i < W; i++) begin
            carry_v[i] = c;
            sum_v[i]   = a_i[i] ^ b_i[i] ^ c;
            c          = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
        end
        add_co = c;
    end

    // both logic vectors are always formed: each predicts the other's parity
    assign and_v = a_i & b_i;
    assign or_v  = a_i | b_i;
    assign xor_v = a_i ^ b_i;

    always_comb begin
        unique case (op_i)
            OP_ADD: begin
                raw_v      = sum_v;
                pred_par_o = a_par_i ^ b_par_i ^ (^carry_v);
                cout_o     = add_co;
            end
            OP_AND: begin
                raw_v      = and_v;
                pred_par_o = a_par_i ^ b_par_i ^ (^or_v);
                cout_o     = 1'b0;
            end
            OP_OR: begin
                raw_v      = or_v;
                pred_par_o = a_par_i ^ b_par_i ^ (^and_v);
                cout_o     = 1'b0;
            end
            default: begin
                raw_v      = xor_v;
                pred_par_o = a_par_i ^ b_par_i;
                cout_o     = 1'b0;
            end
        endcase
    end

    // produced word, including any injected corruption
    assign res_o   = raw_v ^ flt_i;
    assign par_bad = (^res_o) ^ pred_par_o;

    chk_mod3_tree #(.NB(W)) u_rsd_a (
        .val_i (a_i),
        .res_o (r_a)
    );

    chk_mod3_tree #(.NB(W)) u_rsd_b (
        .val_i (b_i),
        .res_o (r_b)
    );

    chk_mod3_tree #(.NB(SW)) u_rsd_s (
        .val_i ({cout_o, res_o}),
        .res_o (r_s)
    );

    assign r_exp   = m3_add(m3_add(r_a, r_b), {1'b0, cin_i});
    assign rsd_bad = (op_i == OP_ADD) && (r_exp != r_s);
    assign mism_o  = par_bad | rsd_bad;

endmodule

// File: rtl/checked_alu.sv
module checked_alu
    import chk_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic         a_par_i,
    input  logic [W-1:0] b_i,
    input  logic         b_par_i,
    input  logic         cin_i,
    input  logic [W-1:0] flt_mask_i,
    input  logic         clr_fatal_i,
    output logic         res_valid_o,
    output logic [W-1:0] res_o,
    output logic         res_par_o,
    output logic         cout_o,
    output logic         in_err_o,
    output logic         alu_err_o,
    output logic         fatal_o
);

    typedef struct packed {
        seq_st_e      st;
        alu_op_e      op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic         pa;
        logic         pb;
        logic         vld;
        logic [W-1:0] res;
        logic         par;
        logic         cout;
        logic         in_err;
        logic         alu_err;
        logic         fatal;
    } regs_t;

    regs_t        q, d;
    logic         use_held;
    alu_op_e      core_op;
    logic [W-1:0] core_a;
    logic [W-1:0] core_b;
    logic         core_cin;
    logic         core_pa;
    logic         core_pb;
    logic [W-1:0] core_res;
    logic         core_cout;
    logic         core_par;
    logic         core_mism;
    logic         in_bad;
    logic         fatal_set;
    logic         retry_pend;

    // retry re-executes the held copy; otherwise the live inputs
    assign use_held = (q.st == ST_RETRY);
    assign core_op  = use_held ? q.op  : alu_op_e'(op_i);
    assign core_a   = use_held ? q.a   : a_i;
    assign core_b   = use_held ? q.b   : b_i;
    assign core_cin = use_held ? q.cin : cin_i;
    assign core_pa  = use_held ? q.pa  : a_par_i;
    assign core_pb  = use_held ? q.pb  : b_par_i;

    chk_alu_core #(.W(W)) u_core (
        .op_i       (core_op),
        .a_i        (core_a),
        .b_i        (core_b),
        .cin_i      (core_cin),
        .a_par_i    (core_pa),
        .b_par_i    (core_pb),
        .flt_i      (flt_mask_i),
        .res_o      (core_res),
        .cout_o     (core_cout),
        .pred_par_o (core_par),
        .mism_o     (core_mism)
    );

    assign in_bad = ((^a_i) ^ a_par_i) | ((^b_i) ^ b_par_i);

    always_comb begin
        d         = q;
        d.vld     = 1'b0;
        d.in_err  = 1'b0;
        d.alu_err = 1'b0;
        fatal_set = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (valid_i) begin
                    d.op  = alu_op_e'(op_i);
                    d.a   = a_i;
                    d.b   = b_i;
                    d.cin = cin_i;
                    d.pa  = a_par_i;
                    d.pb  = b_par_i;
                    if (in_bad) begin
                        d.vld    = 1'b1;
                        d.res    = core_res;
                        d.par    = core_par;
                        d.cout   = core_cout;
                        d.in_err = 1'b1;
                    end else if (core_mism) begin
                        d.st = ST_GAP;
                    end else begin
                        d.vld  = 1'b1;
                        d.res  = core_res;
                        d.par  = core_par;
                        d.cout = core_cout;
                    end
                end
            end
            ST_GAP: begin
                d.st = ST_RETRY;
            end
            ST_RETRY: begin
                d.vld     = 1'b1;
                d.res     = core_res;
                d.par     = core_par;
                d.cout    = core_cout;
                d.alu_err = 1'b1;
                fatal_set = core_mism;
                d.st      = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
        d.fatal = fatal_set | (q.fatal & ~clr_fatal_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign retry_pend  = (q.st != ST_IDLE);
    assign res_valid_o = q.vld;
    assign res_o       = q.res;
    assign res_par_o   = q.par;
    assign cout_o      = q.cout;
    assign in_err_o    = q.in_err;
    assign alu_err_o   = q.alu_err;
    assign fatal_o     = q.fatal;

endmodule

// File: rtl/checked_alu_sva.sv
module checked_alu_sva #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         clr_fatal_i,
    input logic         res_valid_o,
    input logic [W-1:0] res_o,
    input logic         res_par_o,
    input logic         in_err_o,
    input logic         alu_err_o,
    input logic         fatal_o,
    input logic         retry_pend
);

    p_par_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !in_err_o && !alu_err_o) |-> ((^res_o) == res_par_o));

    p_retry_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(retry_pend) |=> !res_valid_o ##1 (res_valid_o && alu_err_o));

    p_fatal_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fatal_o && !clr_fatal_i) |=> fatal_o);

    p_fatal_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_fatal_i && !retry_pend) |=> !fatal_o);

    p_fatal_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fatal_o) |-> alu_err_o);

    p_in_err_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_err_o |-> (res_valid_o && !alu_err_o));

endmodule

bind checked_alu checked_alu_sva #(.W(W)) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_fatal_i (clr_fatal_i),
    .res_valid_o (res_valid_o),
    .res_o       (res_o),
    .res_par_o   (res_par_o),
    .in_err_o    (in_err_o),
    .alu_err_o   (alu_err_o),
    .fatal_o     (fatal_o),
    .retry_pend  (retry_pend)
);

// File: tb/checked_alu_bench.sv
module checked_alu_bench;

    localparam int W = 4;

    logic         clk_i = 1'b0;
    logic         rst_ni;
    logic         valid_i;
    logic [1:0]   op_i;
    logic [W-1:0] a_i;
    logic         a_par_i;
    logic [W-1:0] b_i;
    logic         b_par_i;
    logic         cin_i;
    logic [W-1:0] flt_mask_i;
    logic         clr_fatal_i;
    logic         res_valid_o;
    logic [W-1:0] res_o;
    logic         res_par_o;
    logic         cout_o;
    logic         in_err_o;
    logic         alu_err_o;
    logic         fatal_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  exp_fatal = 1'b0;
    bit  done = 1'b0;

    checked_alu #(.W(W)) u_checked_alu (.*);

    always #4 clk_i = ~clk_i;

    function automatic logic [W:0] gold(int op, logic [W-1:0] a, logic [W-1:0] b, logic cin);
        case (op)
            0:       return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            1:       return {1'b0, a & b};
            2:       return {1'b0, a | b};
            default: return {1'b0, a ^ b};
        endcase
    endfunction

    function automatic bit detect(int op, logic [W-1:0] a, logic [W-1:0] b, logic cin,
                                  logic [W-1:0] m);
        logic [W:0] g;
        logic [W:0] c;
        g = gold(op, a, b, cin);
        if (^m) return 1'b1;
        if (op != 0) return 1'b0;
        c = {g[W], g[W-1:0] ^ m};
        return (int'(c) % 3) != (int'(g) % 3);
    endfunction

    function automatic logic [31:0] pack_out();
        return 32'({res_valid_o, res_o, res_par_o, cout_o, in_err_o, alu_err_o, fatal_o});
    endfunction

    function automatic logic [31:0] pack_exp(bit v, logic [W-1:0] r, bit p, bit c, bit ie,
                                             bit ae, bit f);
        return 32'({v, r, p, c, ie, ae, f});
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic run_op(int op, logic [W-1:0] a, logic [W-1:0] b, logic cin, bit fa, bit fb,
                          logic [W-1:0] m1, logic [W-1:0] m2, bit clr_retry, bit poke,
                          string req);
        logic [W:0] g;
        bit         inb;
        bit         d1;
        bit         d2;
        g   = gold(op, a, b, cin);
        inb = fa | fb;
        d1  = !inb && detect(op, a, b, cin, m1);
        op_i = 2'(op); a_i = a; b_i = b; cin_i = cin;
        a_par_i = (^a) ^ fa; b_par_i = (^b) ^ fb;
        flt_mask_i = m1; valid_i = 1'b1;
        @(negedge clk_i);
        valid_i = 1'b0;
        if (!d1) begin
            chk(req, pack_out(),
                pack_exp(1'b1, g[W-1:0] ^ m1, (^g[W-1:0]) ^ fa ^ fb, g[W], inb, 1'b0,
                         exp_fatal));
        end else begin
            chk({req, " R4 first attempt silent"}, 32'(res_valid_o), 32'd0);
            flt_mask_i = m2;
            if (poke) begin
                valid_i = 1'b1; a_i = ~a; b_i = ~b; op_i = 2'd3;
                a_par_i = ^(~a); b_par_i = ^(~b);
            end
            @(negedge clk_i);
            valid_i = 1'b0;
            chk(poke ? "R7 gap ignores strobe" : "R4 gap cycle", 32'(res_valid_o), 32'd0);
            clr_fatal_i = clr_retry;
            @(negedge clk_i);
            clr_fatal_i = 1'b0;
            d2 = detect(op, a, b, cin, m2);
            if (clr_retry) exp_fatal = d2;
            else           exp_fatal = exp_fatal | d2;
            chk({req, " R4 R5 retry delivery"}, pack_out(),
                pack_exp(1'b1, g[W-1:0] ^ m2, ^g[W-1:0], g[W], 1'b0, 1'b1, exp_fatal));
        end
        flt_mask_i = '0;
    endtask

    task automatic pulse_clear();
        clr_fatal_i = 1'b1;
        @(negedge clk_i);
        clr_fatal_i = 1'b0;
        exp_fatal = 1'b0;
        chk("R5 clear", 32'(fatal_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
        a_par_i = 1'b0; b_par_i = 1'b0; cin_i = 1'b0; flt_mask_i = '0; clr_fatal_i = 1'b0;
        repeat (3) @(negedge clk_i);
        chk("R8 reset outputs", pack_out(), 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R8 idle after reset", pack_out(), 32'd0);

        // R1 R2: exhaustive clean sweep
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    for (int c = 0; c < 2; c++)
                        run_op(op, W'(a), W'(b), c[0], 0, 0, '0, '0, 0, 0, "R1 R2 clean op");

        // R3 R4: add with injected corruption, clean retry
        for (int a = 0; a < (1 << W); a++)
            for (int m = 1; m < (1 << W); m++)
                run_op(0, W'(a), W'(a * 7 + m), m[0], 0, 0, W'(m), '0, 0, 0, "R3 add fault");

        // R3: logic ops detect odd-weight corruption only
        for (int op = 1; op < 4; op++)
            for (int m = 1; m < (1 << W); m++)
                run_op(op, W'(m * 3), W'(m ^ 5), 1'b0, 0, 0, W'(m), '0, 0, 0, "R3 logic fault");

        // R6: operand parity faults, with and without corruption
        for (int op = 0; op < 4; op++)
            for (int k = 1; k < 4; k++)
                run_op(op, W'(op * 5 + k), W'(k * 3), k[0], k[0], k[1], W'(k), '0, 0, 0,
                       "R6 input parity");

        // R5: retry failure sets sticky flag
        run_op(0, 4'd6, 4'd9, 1'b1, 0, 0, 4'd1, 4'd2, 0, 0, "R5 retry fails");
        chk("R5 fatal set", 32'(fatal_o), 32'd1);
        run_op(2, 4'd3, 4'd4, 1'b0, 0, 0, '0, '0, 0, 0, "R5 fatal persists");
        @(negedge clk_i);
        chk("R5 fatal holds idle", 32'(fatal_o), 32'd1);
        pulse_clear();
        // R5: failure and clear on the same edge, set wins
        run_op(1, 4'd7, 4'd5, 1'b0, 0, 0, 4'd8, 4'd4, 1, 0, "R5 set beats clear");
        chk("R5 set beats clear flag", 32'(fatal_o), 32'd1);
        // R5: clean retry with clear on the same edge clears it
        run_op(0, 4'd2, 4'd3, 1'b0, 0, 0, 4'd1, '0, 1, 0, "R5 clear at clean retry");
        chk("R5 cleared at retry", 32'(fatal_o), 32'd0);

        // R7: strobe during recovery is dropped
        run_op(0, 4'd11, 4'd13, 1'b1, 0, 0, 4'd4, '0, 0, 1, "R7 busy strobe");
        @(negedge clk_i);
        chk("R7 no extra result", 32'(res_valid_o), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule